// File: doc/BRIEF.md
# Multi-Mode Watchdog with Sleep Wake-Up

This block is the watchdog counter of a small microcontroller. It counts pulses of a tick enable taken from a free-running low-frequency oscillator of about 31 kHz. That oscillator is independent of the system clock, and its pulses are already brought into the system clock domain. A prescaler turns the pulses into a nominal 1 ms base. A five-bit period code then picks a timeout that is a power of two in milliseconds. If software does not issue a clear command before the timeout, the block acts. While the device is awake it requests a device reset. While the device is asleep, in a mode that keeps the watchdog running, it only requests a wake-up.

A two-bit mode field selects one of four behaviours: always running, running only while awake, gated by a software enable bit, or never running. Several events restart the count from zero:

- the clear command
- any reset that does not come from the watchdog
- the oscillator start-up timer being busy
- entry into sleep
- exit from sleep
- the watchdog becoming disabled

Three active-low status flags record the cause of the last event. Power-on reset and the clear command set them back to one.

Top module: `sleepwake_watchdog`

## Requirements
- R1: The mode code selects when the count runs: 2'b11 runs always, including during sleep; 2'b10 runs only while awake; 2'b01 runs only while `sw_en` is 1 (asleep or awake); 2'b00 never runs and never raises a request.
- R2: `lf_tick` is a single-cycle enable. The millisecond count advances once every `PRESCALE_DIV` accepted pulses of it (default 31).
- R3: For a period code n below `MAX_CODE` (default 18), the timeout comes after `PRESCALE_DIV`·2^n pulses of `lf_tick`. Codes of `MAX_CODE` or more use 2^`MAX_CODE` ms.
- R4: A cycle with `clear_cmd`, `ext_rst` or `ost_busy` high restarts the whole count from zero, including the prescaler phase.
- R5: A `sleep_enter` or `sleep_exit` pulse restarts the whole count from zero.
- R6: A cycle in which the watchdog is disabled (for example, `sw_en` low in mode 2'b01) restarts the count from zero.
- R7: A timeout while awake raises `rst_req` for exactly one cycle. It appears on the clock edge that takes the expiring tick, and it drives `to_n` and `wdtrst_n` low.
- R8: A timeout while asleep raises only `wake_req`, for exactly one cycle. It drives `to_n` and `pwr_n` low and leaves the sleep state, so that a later timeout is handled as an awake one.
- R9: In mode 2'b10 the count is held at zero and no request occurs while asleep. After `sleep_exit` a full period is counted from zero.
- R10: After either request the count restarts, so the next request needs a full period again.
- R11: After power-on reset, `rst_req` and `wake_req` are 0 and all three flags are 1. A `clear_cmd` sets all three flags back to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| lf_tick | input | 1 | One-cycle enable per low-frequency oscillator pulse |
| mode_cfg | input | 2 | Enable mode code (see R1) |
| sw_en | input | 1 | Software enable bit, used in mode 2'b01 |
| period_sel | input | SEL_W | Period code n, timeout 2^n ms |
| clear_cmd | input | 1 | Software clear command |
| sleep_enter | input | 1 | Pulse when the device enters sleep |
| sleep_exit | input | 1 | Pulse when the device leaves sleep |
| ext_rst | input | 1 | Reset from a source other than the watchdog |
| ost_busy | input | 1 | Oscillator start-up timer is running |
| rst_req | output | 1 | One-cycle device reset request |
| wake_req | output | 1 | One-cycle wake-from-sleep request |
| to_n | output | 1 | Time-out flag, low after any timeout |
| wdtrst_n | output | 1 | Low after a timeout that reset the device |
| pwr_n | output | 1 | Low after a timeout that woke the device |

## Verification
The assertions rely on a few properties of the inputs:

- `sleep_enter` and `sleep_exit` are never high in the same cycle.
- `lf_tick` is already synchronous to `clk`.
- Inputs change away from the rising edge.

The bench drives every input at falling edges, pulses each sleep indication on its own, and lowers the other clear sources between tests. This keeps each timeout measurement a clean count of `lf_tick` pulses from a known restart.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        WD_OFF   = 2'b00,
        WD_SOFT  = 2'b01,
        WD_AWAKE = 2'b10,
        WD_ON    = 2'b11
    } wd_mode_e;

    typedef struct packed {
        logic to_n;
        logic wdtrst_n;
        logic pwr_n;
    } wd_flags_t;

    localparam wd_flags_t FLAGS_IDLE = '{to_n: 1'b1, wdtrst_n: 1'b1, pwr_n: 1'b1};

endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
    parameter int DIV = 31
) (
    input  logic clk,
    input  logic por_n,
    input  logic tick,
    input  logic clr,
    output logic ms_tick
);
    localparam int PRE_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PRE_W-1:0] LAST = PRE_W'(DIV - 1);

    logic [PRE_W-1:0] phase_d, phase_q;

    always_comb begin
        phase_d = phase_q;
        ms_tick = 1'b0;
        if (clr) begin
            phase_d = '0;
        end else if (tick) begin
            if (phase_q == LAST) begin
                phase_d = '0;
                ms_tick = 1'b1;
            end else begin
                phase_d = phase_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) phase_q <= '0;
        else        phase_q <= phase_d;
    end

endmodule

// File: rtl/wdog_period.sv
module wdog_period #(
    parameter int SEL_W    = 5,
    parameter int MAX_CODE = 18,
    parameter int CNT_W    = 18
) (
    input  logic [SEL_W-1:0] sel,
    output logic [CNT_W-1:0] limit_m1
);
    logic [CNT_W:0] pow;
    int             eff;

    always_comb begin
        eff      = (int'(sel) > MAX_CODE) ? MAX_CODE : int'(sel);
        pow      = (CNT_W + 1)'(1) << eff;
        limit_m1 = CNT_W'(pow - 1'b1);
    end

endmodule

// File: rtl/wdog_enable.sv
module wdog_enable
    import wdog_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       sw_en,
    input  logic       asleep,
    output logic       run
);
    always_comb begin
        unique case (wd_mode_e'(mode))
            WD_ON:    run = 1'b1;
            WD_AWAKE: run = !asleep;
            WD_SOFT:  run = sw_en;
            default:  run = 1'b0;
        endcase
    end

endmodule

// File: rtl/sleepwake_watchdog.sv
module sleepwake_watchdog
    import wdog_pkg::*;
#(
    parameter int PRESCALE_DIV = 31,
    parameter int SEL_W        = 5,
    parameter int MAX_CODE     = 18
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             lf_tick,
    input  logic [1:0]       mode_cfg,
    input  logic             sw_en,
    input  logic [SEL_W-1:0] period_sel,
    input  logic             clear_cmd,
    input  logic             sleep_enter,
    input  logic             sleep_exit,
    input  logic             ext_rst,
    input  logic             ost_busy,
    output logic             rst_req,
    output logic             wake_req,
    output logic             to_n,
    output logic             wdtrst_n,
    output logic             pwr_n
);
    localparam int CNT_W = (MAX_CODE > 0) ? MAX_CODE : 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             asleep;
        logic             rst_req;
        logic             wake_req;
        wd_flags_t        flags;
    } state_t;

    localparam state_t STATE_RST = '{cnt: '0, asleep: 1'b0, rst_req: 1'b0,
                                     wake_req: 1'b0, flags: FLAGS_IDLE};

    state_t           st_d, st_q;
    logic             run;
    logic             clr_any;
    logic             ms_tick;
    logic [CNT_W-1:0] limit_m1;
    logic             asleep_w;

    wdog_enable i_enable (
        .mode   (mode_cfg),
        .sw_en  (sw_en),
        .asleep (st_q.asleep),
        .run    (run)
    );

    wdog_period #(
        .SEL_W    (SEL_W),
        .MAX_CODE (MAX_CODE),
        .CNT_W    (CNT_W)
    ) i_period (
        .sel      (period_sel),
        .limit_m1 (limit_m1)
    );

    assign clr_any = clear_cmd || ext_rst || ost_busy || sleep_enter
                  || sleep_exit || !run;

    wdog_prescale #(
        .DIV (PRESCALE_DIV)
    ) i_prescale (
        .clk     (clk),
        .por_n   (por_n),
        .tick    (lf_tick),
        .clr     (clr_any),
        .ms_tick (ms_tick)
    );

    always_comb begin
        st_d          = st_q;
        st_d.rst_req  = 1'b0;
        st_d.wake_req = 1'b0;

        if (sleep_enter)     st_d.asleep = 1'b1;
        else if (sleep_exit) st_d.asleep = 1'b0;

        if (clr_any) begin
            st_d.cnt = '0;
        end else if (ms_tick) begin
            if (st_q.cnt >= limit_m1) begin
                st_d.cnt        = '0;
                st_d.flags.to_n = 1'b0;
                if (st_q.asleep) begin
                    st_d.wake_req    = 1'b1;
                    st_d.asleep      = 1'b0;
                    st_d.flags.pwr_n = 1'b0;
                end else begin
                    st_d.rst_req        = 1'b1;
                    st_d.flags.wdtrst_n = 1'b0;
                end
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end

        if (clear_cmd) st_d.flags = FLAGS_IDLE;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= STATE_RST;
        else        st_q <= st_d;
    end

    assign rst_req  = st_q.rst_req;
    assign wake_req = st_q.wake_req;
    assign to_n     = st_q.flags.to_n;
    assign wdtrst_n = st_q.flags.wdtrst_n;
    assign pwr_n    = st_q.flags.pwr_n;
    assign asleep_w = st_q.asleep;

endmodule

// File: rtl/wdog_checks.sv
module wdog_checks (
    input logic       clk,
    input logic       por_n,
    input logic [1:0] mode_cfg,
    input logic       clear_cmd,
    input logic       ext_rst,
    input logic       ost_busy,
    input logic       asleep,
    input logic       rst_req,
    input logic       wake_req,
    input logic       to_n,
    input logic       wdtrst_n,
    input logic       pwr_n
);
    a_r7_rst_single: assert property (@(posedge clk) disable iff (!por_n)
        rst_req |=> !rst_req);

    a_r8_wake_single: assert property (@(posedge clk) disable iff (!por_n)
        wake_req |=> !wake_req);

    a_r7_r8_exclusive: assert property (@(posedge clk) disable iff (!por_n)
        !(rst_req && wake_req));

    a_r7_flags_low: assert property (@(posedge clk) disable iff (!por_n)
        rst_req |-> (!to_n && !wdtrst_n));

    a_r8_flags_low: assert property (@(posedge clk) disable iff (!por_n)
        wake_req |-> (!to_n && !pwr_n));

    a_r8_wake_from_sleep: assert property (@(posedge clk) disable iff (!por_n)
        wake_req |-> $past(asleep));

    a_r1_off_silent: assert property (@(posedge clk) disable iff (!por_n)
        (mode_cfg == 2'b00) |=> !(rst_req || wake_req));

    a_r4_clear_no_req: assert property (@(posedge clk) disable iff (!por_n)
        (clear_cmd || ext_rst || ost_busy) |=> !(rst_req || wake_req));

    a_r11_clear_flags: assert property (@(posedge clk) disable iff (!por_n)
        clear_cmd |=> (to_n && wdtrst_n && pwr_n));

    a_r9_hold_in_sleep: assert property (@(posedge clk) disable iff (!por_n)
        (mode_cfg == 2'b10 && asleep) |=> !(rst_req || wake_req));

endmodule

bind sleepwake_watchdog wdog_checks i_checks (
    .clk       (clk),
    .por_n     (por_n),
    .mode_cfg  (mode_cfg),
    .clear_cmd (clear_cmd),
    .ext_rst   (ext_rst),
    .ost_busy  (ost_busy),
    .asleep    (asleep_w),
    .rst_req   (rst_req),
    .wake_req  (wake_req),
    .to_n      (to_n),
    .wdtrst_n  (wdtrst_n),
    .pwr_n     (pwr_n)
);

// File: tb/test_sleepwake_watchdog.sv
module test_sleepwake_watchdog;
    localparam int DIV   = 3;
    localparam int SEL_W = 5;
    localparam int MAXC  = 5;

    logic             clk = 1'b0;
    logic             por_n = 1'b0;
    logic             lf_tick = 1'b0;
    logic [1:0]       mode_cfg = 2'b11;
    logic             sw_en = 1'b0;
    logic [SEL_W-1:0] period_sel = '0;
    logic             clear_cmd = 1'b0;
    logic             sleep_enter = 1'b0;
    logic             sleep_exit = 1'b0;
    logic             ext_rst = 1'b0;
    logic             ost_busy = 1'b0;
    logic             rst_req, wake_req, to_n, wdtrst_n, pwr_n;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #2 clk = ~clk;

    sleepwake_watchdog #(
        .PRESCALE_DIV (DIV),
        .SEL_W        (SEL_W),
        .MAX_CODE     (MAXC)
    ) i_sleepwake_watchdog (
        .clk, .por_n, .lf_tick, .mode_cfg, .sw_en, .period_sel, .clear_cmd,
        .sleep_enter, .sleep_exit, .ext_rst, .ost_busy,
        .rst_req, .wake_req, .to_n, .wdtrst_n, .pwr_n
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int period_of(input int code);
        int e = (code > MAXC) ? MAXC : code;
        return DIV * (1 << e);
    endfunction

    // sel: 0 clear, 1 external reset, 2 start-up busy, 3 sleep entry, 4 sleep exit
    task automatic pulse_in(input int sel);
        @(negedge clk);
        case (sel)
            0: clear_cmd   = 1'b1;
            1: ext_rst     = 1'b1;
            2: ost_busy    = 1'b1;
            3: sleep_enter = 1'b1;
            default: sleep_exit = 1'b1;
        endcase
        @(negedge clk);
        clear_cmd = 1'b0; ext_rst = 1'b0; ost_busy = 1'b0;
        sleep_enter = 1'b0; sleep_exit = 1'b0;
    endtask

    task automatic ticks_until(input int maxt, output int n, output logic rq, output logic wk);
        n = 0; rq = 1'b0; wk = 1'b0;
        @(negedge clk);
        lf_tick = 1'b1;
        while (n < maxt) begin
            @(negedge clk);
            n++;
            if (rst_req || wake_req) begin
                rq = rst_req; wk = wake_req;
                break;
            end
        end
        lf_tick = 1'b0;
    endtask

    task automatic ticks(input int k);
        @(negedge clk);
        lf_tick = 1'b1;
        repeat (k) @(negedge clk);
        lf_tick = 1'b0;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(4 * 100000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        int   n;
        logic rq, wk;

        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(!rst_req && !wake_req, "R11 requests after reset", int'(rst_req | wake_req), 0);
        chk(to_n && wdtrst_n && pwr_n, "R11 flags after reset",
            int'({to_n, wdtrst_n, pwr_n}), 7);

        // R1 R2 R3 R7 R10: sweep of period codes in always-on mode, awake
        mode_cfg = 2'b11;
        for (int code = 0; code <= MAXC + 2; code++) begin
            pulse_in(0);
            period_sel = SEL_W'(code);
            for (int rep = 0; rep < 2; rep++) begin
                ticks_until(period_of(code) + 4, n, rq, wk);
                chk(n == period_of(code), "R3 timeout tick count", n, period_of(code));
                chk(rq && !wk, "R7 awake timeout gives reset only", int'({rq, wk}), 2);
                chk(!to_n && !wdtrst_n && pwr_n, "R7 flags after reset request",
                    int'({to_n, wdtrst_n, pwr_n}), 1);
                @(negedge clk);
                chk(!rst_req, "R7 reset request lasts one cycle", int'(rst_req), 0);
            end
        end
        // R11 clear restores flags
        pulse_in(0);
        chk(to_n && wdtrst_n && pwr_n, "R11 clear restores flags",
            int'({to_n, wdtrst_n, pwr_n}), 7);

        // R4: partial count then each clear source restarts fully
        period_sel = SEL_W'(2);
        for (int src = 0; src < 3; src++) begin
            ticks(7);
            pulse_in(src);
            ticks_until(period_of(2) + 4, n, rq, wk);
            chk(n == period_of(2) && rq, "R4 clear source restarts count", n, period_of(2));
        end

        // R1 mode off: never requests
        mode_cfg = 2'b00;
        ticks_until(200, n, rq, wk);
        chk(!rq && !wk, "R1 mode 00 silent", int'({rq, wk}), 0);

        // R1 software mode, enable low then high
        mode_cfg = 2'b01; sw_en = 1'b0;
        ticks_until(200, n, rq, wk);
        chk(!rq && !wk, "R1 mode 01 with sw_en low silent", int'({rq, wk}), 0);
        sw_en = 1'b1;
        ticks_until(period_of(2) + 4, n, rq, wk);
        chk(n == period_of(2) && rq, "R1 mode 01 with sw_en high runs", n, period_of(2));

        // R6: disabling for one cycle restarts the count
        ticks(7);
        @(negedge clk); sw_en = 1'b0;
        @(negedge clk); sw_en = 1'b1;
        ticks_until(period_of(2) + 4, n, rq, wk);
        chk(n == period_of(2) && rq, "R6 disable restarts count", n, period_of(2));

        // R1 R8: software mode keeps running in sleep and wakes
        pulse_in(0);
        pulse_in(3);
        ticks_until(period_of(2) + 4, n, rq, wk);
        chk(n == period_of(2) && wk && !rq, "R1 mode 01 wakes from sleep", n, period_of(2));

        // R5 R8: always-on mode, sleep entry restarts, timeout wakes
        mode_cfg = 2'b11; period_sel = SEL_W'(1);
        pulse_in(0);
        ticks(4);
        pulse_in(3);
        ticks_until(period_of(1) + 4, n, rq, wk);
        chk(n == period_of(1), "R5 sleep entry restarts count", n, period_of(1));
        chk(wk && !rq, "R8 sleep timeout gives wake only", int'({rq, wk}), 1);
        chk(!to_n && wdtrst_n && !pwr_n, "R8 flags after wake",
            int'({to_n, wdtrst_n, pwr_n}), 2);
        @(negedge clk);
        chk(!wake_req, "R8 wake request lasts one cycle", int'(wake_req), 0);
        ticks_until(period_of(1) + 4, n, rq, wk);
        chk(rq && !wk && n == period_of(1), "R8 wake leaves sleep state", int'({rq, wk}), 2);

        // R5: sleep exit restarts
        pulse_in(0);
        pulse_in(3);
        ticks(4);
        pulse_in(4);
        ticks_until(period_of(1) + 4, n, rq, wk);
        chk(n == period_of(1) && rq && !wk, "R5 sleep exit restarts count", n, period_of(1));

        // R9: awake-only mode holds during sleep
        mode_cfg = 2'b10;
        pulse_in(0);
        ticks(3);
        pulse_in(3);
        ticks_until(200, n, rq, wk);
        chk(!rq && !wk, "R9 no request while asleep in mode 10", int'({rq, wk}), 0);
        pulse_in(4);
        ticks_until(period_of(1) + 4, n, rq, wk);
        chk(n == period_of(1) && rq, "R9 full period after exit", n, period_of(1));

        // R11: power-on reset restores flags
        @(negedge clk); por_n = 1'b0;
        @(negedge clk); por_n = 1'b1;
        @(negedge clk);
        chk(to_n && wdtrst_n && pwr_n && !rst_req, "R11 power-on restores flags",
            int'({to_n, wdtrst_n, pwr_n}), 7);

        finish_run();
    end

endmodule